// File: doc/BRIEF.md
# HDLC Frame Address Filter

This block sits on the receive path of an HDLC controller. It comes after flag detection and zero-bit removal. It watches the byte stream of each frame and looks only at the address field. That field starts with the first byte after the opening flag, and the control byte follows it. The block decides whether the frame is meant for this station. Software loads four 16-bit station addresses and one 16-bit mask. All four addresses are compared with the received address at the same time, through that one shared mask. A mask bit of 0 takes that address bit out of the comparison.

The block handles two address lengths. In narrow mode the address is one byte long. In wide mode it is two bytes long, with the first byte placed in the low half of the comparison word. For narrow filtering, the mask is normally 0x00FF so that the upper byte is ignored. For full 16-bit matching, the mask is 0xFFFF, and one slot may hold a broadcast value such as 0xFFFF. A promiscuous input accepts every frame that carries a complete address.

The result is a registered decision with three parts: a valid flag, an accept flag and the index of the lowest matching slot. The frame buffering logic downstream reads it and keeps or drops the frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_index` are all 0.
- R2: In narrow mode (`cfg_wide`=0), the address word is {8'h00, first byte}. The first byte is the byte with `rx_valid` and `rx_sof` high. The decision is valid on the clock after that byte is sampled.
- R3: In wide mode (`cfg_wide`=1), the first byte forms bits 7:0 and the next valid byte forms bits 15:8. `dec_valid` is 0 from the clock after the start byte until the clock after the second byte, when it becomes 1.
- R4: Slot i (bits 16i+15:16i of `cfg_addr`) matches when `(word ^ slot) & cfg_mask` is 0. A frame is accepted when any slot matches.
- R5: `dec_index` gives the lowest-numbered matching slot. It is 0 when no slot matches.
- R6: When `cfg_promisc` is 1, a frame with a complete address is accepted. `dec_index` still follows R5.
- R7: In wide mode, a frame whose start byte also carries `rx_eof` gives `dec_valid`=1 and `dec_accept`=0 on the next clock, even when `cfg_promisc` is 1.
- R8: A decision holds unchanged until the next start byte. Later bytes of the frame do not change it, and neither does a clock with `rx_valid` low. A clock with `rx_valid` low between the two address bytes is skipped.
- R9: Changes to the configuration inputs after the decision is made do not change the held decision.
- R10: In wide mode, a start byte that arrives while the second address byte is still awaited restarts address capture from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = two-byte address, 0 = one-byte address |
| cfg_promisc | input | 1 | Accept every frame that has a complete address |
| cfg_mask | input | 16 | Compare mask; a 0 bit is ignored |
| cfg_addr | input | 64 | Four station addresses, slot i at bits 16i+15:16i |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_eof | input | 1 | Marks the last byte of a frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| dec_valid | output | 1 | The decision for the current frame is available |
| dec_accept | output | 1 | The frame is accepted |
| dec_index | output | 2 | Lowest matching slot |

## Verification
If the capture state machine is left in the wrong state, the error shows at the ports within one byte. Either `dec_valid` rises after the first byte of a wide frame, or it never rises, or a later byte of the frame overwrites a decision that should hold. A swapped byte order or a broken mask bit shows up as a wrong accept or index on the clock after the last address byte. The frames are therefore chosen so that each wrong order or mask produces a different expected value. A priority error shows only when several slots match at once, so duplicate slot contents are part of the stimulus.

// File: rtl/hafilt_pkg.sv
package hafilt_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 2 * BYTE_W;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_WAIT_HI = 2'd1,
        CAP_DONE    = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic              restart;
        logic              complete;
        logic              truncated;
        logic [ADDR_W-1:0] word;
    } capture_t;

    function automatic logic masked_equal(
        input logic [ADDR_W-1:0] rcv,
        input logic [ADDR_W-1:0] ref_addr,
        input logic [ADDR_W-1:0] mask
    );
        return ((rcv ^ ref_addr) & mask) == '0;
    endfunction

endpackage

// File: rtl/hafilt_capture.sv
module hafilt_capture
    import hafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_data,
    output capture_t          cap
);

    cap_state_e        state_q, state_d;
    logic [BYTE_W-1:0] lo_q;

    always_comb begin
        cap     = '0;
        state_d = state_q;
        if (rx_valid) begin
            if (rx_sof) begin
                cap.restart = 1'b1;
                if (!wide) begin
                    cap.complete = 1'b1;
                    cap.word     = {{BYTE_W{1'b0}}, rx_data};
                    state_d      = CAP_DONE;
                end else if (rx_eof) begin
                    cap.truncated = 1'b1;
                    state_d       = CAP_DONE;
                end else begin
                    state_d = CAP_WAIT_HI;
                end
            end else if (state_q == CAP_WAIT_HI) begin
                cap.complete = 1'b1;
                cap.word     = {rx_data, lo_q};
                state_d      = CAP_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_IDLE;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rx_valid && rx_sof) begin
                lo_q <= rx_data;
            end
        end
    end

    AST_GAP_KEEPS_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAP_WAIT_HI && !rx_valid) |=> state_q == CAP_WAIT_HI); // R8

    AST_WAIT_FROM_WIDE_SOF: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && wide && !rx_eof) |=> state_q == CAP_WAIT_HI); // R10

endmodule

// File: rtl/hafilt_match.sv
module hafilt_match
    import hafilt_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [ADDR_W-1:0]       word,
    input  logic [ADDR_W-1:0]       mask,
    input  logic [SLOTS*ADDR_W-1:0] slots,
    output logic                    hit,
    output logic [IDX_W-1:0]        index
);

    logic [SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = masked_equal(word, slots[g*ADDR_W +: ADDR_W], mask);
    end

    always_comb begin
        index = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                index = IDX_W'(i);
            end
        end
    end

    assign hit = |hit_vec;

    always_comb begin
        if (hit) begin
            AST_INDEX_IS_HIT: assert (hit_vec[index]); // R5
        end
    end

endmodule

// File: rtl/hafilt_decide.sv
module hafilt_decide
    import hafilt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  capture_t         cap,
    input  logic             promisc,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_index,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [IDX_W-1:0] dec_index
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_index  <= '0;
        end else if (cap.complete) begin
            dec_valid  <= 1'b1;
            dec_accept <= hit || promisc;
            dec_index  <= hit ? hit_index : '0;
        end else if (cap.truncated) begin
            dec_valid  <= 1'b1;
            dec_accept <= 1'b0;
            dec_index  <= '0;
        end else if (cap.restart) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_index  <= '0;
        end
    end

    AST_TRUNC_REJECT: assert property (@(posedge clk) disable iff (rst)
        cap.truncated |=> (dec_valid && !dec_accept)); // R7

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hafilt_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wide,
    input  logic                    cfg_promisc,
    input  logic [ADDR_W-1:0]       cfg_mask,
    input  logic [SLOTS*ADDR_W-1:0] cfg_addr,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [BYTE_W-1:0]       rx_data,
    output logic                    dec_valid,
    output logic                    dec_accept,
    output logic [IDX_W-1:0]        dec_index
);

    capture_t         cap;
    logic             hit;
    logic [IDX_W-1:0] hit_index;

    hafilt_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .wide     (cfg_wide),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_data  (rx_data),
        .cap      (cap)
    );

    hafilt_match #(.SLOTS(SLOTS)) u_match (
        .word  (cap.word),
        .mask  (cfg_mask),
        .slots (cfg_addr),
        .hit   (hit),
        .index (hit_index)
    );

    hafilt_decide #(.IDX_W(IDX_W)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .cap        (cap),
        .promisc    (cfg_promisc),
        .hit        (hit),
        .hit_index  (hit_index),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_index  (dec_index)
    );

    AST_NARROW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && !cfg_wide) |=> dec_valid); // R2

    AST_WIDE_PENDING: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && cfg_wide && !rx_eof) |=> !dec_valid); // R3

    AST_REJECT_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> dec_index == '0); // R5

    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && !cfg_wide && cfg_promisc) |=> dec_accept); // R6

    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && rx_eof && cfg_wide) |=> (dec_valid && !dec_accept)); // R7

    AST_DECISION_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !(rx_valid && rx_sof))
        |=> (dec_valid && $stable(dec_accept) && $stable(dec_index))); // R8

endmodule

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wide;
    logic        cfg_promisc;
    logic [15:0] cfg_mask;
    logic [63:0] cfg_addr;
    logic        rx_valid;
    logic        rx_sof;
    logic        rx_eof;
    logic [7:0]  rx_data;
    logic        dec_valid;
    logic        dec_accept;
    logic [1:0]  dec_index;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hdlc_addr_filter dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wide   (cfg_wide),
        .cfg_promisc(cfg_promisc),
        .cfg_mask   (cfg_mask),
        .cfg_addr   (cfg_addr),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_index  (dec_index)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic expect_dec(input string req, input bit v, input bit a, input int idx);
        check(req, "dec_valid", int'(dec_valid), int'(v));
        check(req, "dec_accept", int'(dec_accept), int'(a));
        check(req, "dec_index", int'(dec_index), idx);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit s, input bit e);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_sof   = s;
        rx_eof   = e;
        rx_data  = b;
    endtask

    task automatic gap();
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        rx_data  = 8'h00;
    endtask

    task automatic set_slots(input logic [15:0] a0, input logic [15:0] a1,
                             input logic [15:0] a2, input logic [15:0] a3);
        cfg_addr = {a3, a2, a1, a0};
    endtask

    task automatic wide_frame(input logic [7:0] b0, input logic [7:0] b1);
        put_byte(b0, 1'b1, 1'b0);
        put_byte(b1, 1'b0, 1'b0);
        gap();
    endtask

    task automatic t_reset();
        expect_dec("R1", 1'b0, 1'b0, 0);
    endtask

    task automatic t_narrow();
        cfg_wide = 1'b0; cfg_promisc = 1'b0; cfg_mask = 16'h00FF;
        set_slots(16'h1234, 16'hAB55, 16'h0000, 16'h7777);
        put_byte(8'h55, 1'b1, 1'b0); gap();
        expect_dec("R2 R4 upper byte masked", 1'b1, 1'b1, 1);
        put_byte(8'h44, 1'b0, 1'b1); gap();
        put_byte(8'h34, 1'b1, 1'b0); gap();
        expect_dec("R2 slot0 low byte", 1'b1, 1'b1, 0);
        put_byte(8'h99, 1'b1, 1'b1); gap();
        expect_dec("R5 no match", 1'b1, 1'b0, 0);
    endtask

    task automatic t_wide();
        cfg_wide = 1'b1; cfg_promisc = 1'b0; cfg_mask = 16'hFFFF;
        set_slots(16'hAA68, 16'hFFFF, 16'h1111, 16'hAA68);
        put_byte(8'h68, 1'b1, 1'b0); gap();
        expect_dec("R3 pending after first byte", 1'b0, 1'b0, 0);
        gap();
        put_byte(8'hAA, 1'b0, 1'b0); gap();
        expect_dec("R3 R5 R8 station, lowest of duplicates", 1'b1, 1'b1, 0);
        wide_frame(8'hFF, 8'hFF);
        expect_dec("R4 broadcast slot", 1'b1, 1'b1, 1);
        wide_frame(8'hAA, 8'h68);
        expect_dec("R3 byte order", 1'b1, 1'b0, 0);
        cfg_mask = 16'hFF00;
        wide_frame(8'h00, 8'h11);
        expect_dec("R4 partial mask", 1'b1, 1'b1, 2);
        cfg_mask = 16'h0000;
        wide_frame(8'h12, 8'h34);
        expect_dec("R4 zero mask", 1'b1, 1'b1, 0);
    endtask

    task automatic t_promisc();
        cfg_wide = 1'b1; cfg_promisc = 1'b1; cfg_mask = 16'hFFFF;
        set_slots(16'hAA68, 16'hFFFF, 16'h1111, 16'hAA68);
        wide_frame(8'h01, 8'h02);
        expect_dec("R6 promisc no match", 1'b1, 1'b1, 0);
        wide_frame(8'hFF, 8'hFF);
        expect_dec("R6 promisc with match", 1'b1, 1'b1, 1);
        put_byte(8'hFF, 1'b1, 1'b1); gap();
        expect_dec("R7 short frame promisc", 1'b1, 1'b0, 0);
        cfg_promisc = 1'b0;
        put_byte(8'h68, 1'b1, 1'b1); gap();
        expect_dec("R7 short frame", 1'b1, 1'b0, 0);
    endtask

    task automatic t_hold();
        cfg_wide = 1'b1; cfg_promisc = 1'b0; cfg_mask = 16'hFFFF;
        set_slots(16'hAA68, 16'hFFFF, 16'h1111, 16'hAA68);
        put_byte(8'hFF, 1'b1, 1'b0);
        put_byte(8'hFF, 1'b0, 1'b0);
        put_byte(8'h68, 1'b0, 1'b0);
        put_byte(8'hAA, 1'b0, 1'b0);
        gap();
        expect_dec("R8 later bytes ignored", 1'b1, 1'b1, 1);
        cfg_mask = 16'h0000; cfg_promisc = 1'b1; cfg_wide = 1'b0;
        set_slots(16'h0000, 16'h0000, 16'h0000, 16'h0000);
        gap(); gap();
        expect_dec("R9 config change ignored", 1'b1, 1'b1, 1);
        put_byte(8'h00, 1'b0, 1'b1); gap();
        expect_dec("R8 eof byte ignored", 1'b1, 1'b1, 1);
    endtask

    task automatic t_restart();
        cfg_wide = 1'b1; cfg_promisc = 1'b0; cfg_mask = 16'hFFFF;
        set_slots(16'hAA68, 16'hFFFF, 16'h1111, 16'h6811);
        put_byte(8'h11, 1'b1, 1'b0);
        put_byte(8'h68, 1'b1, 1'b0); gap();
        expect_dec("R10 pending after restart", 1'b0, 1'b0, 0);
        put_byte(8'hAA, 1'b0, 1'b0); gap();
        expect_dec("R10 restarted address", 1'b1, 1'b1, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_wide = 1'b0; cfg_promisc = 1'b0; cfg_mask = 16'hFFFF; cfg_addr = '0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        gap();
        t_reset();
        t_narrow();
        t_wide();
        t_promisc();
        t_hold();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule